// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how fast a slow, free-running clock runs, using a fast reference clock as the ruler. Three slow sources are wired in: the output of the system slow-clock mux, an internal RC oscillator divided by 256, and a 32.768 kHz crystal. Software picks a source with a select field and programs a number of slow periods N. It then raises the start bit. The block counts reference cycles across N slow periods and latches the count as the result. It then sets a ready flag, which software polls and may clear.

Each slow source has its own two-flop synchronizer and rising-edge detector in the reference domain. Counting opens on the first synchronized rising edge after start and closes on the Nth edge after that. Because every edge passes through the same latency, the result equals N times the slow period in reference cycles. A continuous mode rearms at once after each window and overwrites the result. A window check compares a crystal measurement against its nominal count and reports whether the crystal is healthy. All control and status pins are plain levels in the reference domain, so the block has no streaming interface and no back-pressure.

Top module: `slow_cal_counter`

## Requirements
- R1: `cfg_sel` picks the measured source at start: 0 = slow-clock mux output, 1 = divided RC oscillator, 2 = 32 kHz crystal, 3 = same as 0.
- R2: A measurement starts only on a 0-to-1 change of `cfg_start`. Holding it high does not start another measurement.
- R3: `result` equals the number of reference cycles between the first synchronized slow rising edge after start and the Nth edge after it, where N = `cfg_cycles` (15 bits).
- R4: With N = 0 the block waits for one slow rising edge, then sets `ready` with `result` = 0.
- R5: `ready` is set in the same cycle that `result` is written. A `ready_clr` pulse clears it, and a start also clears it. `result` changes only in a cycle where `ready` is set.
- R6: The internal counter saturates at all-ones (width `CNT_W`) and does not wrap. `overflow` is then set and stays set until the next start.
- R7: A start edge during a measurement abandons it, clears `ready`, and begins a fresh measurement with the current fields.
- R8: With `cfg_cont` = 1 at start, each completed window writes `result`, sets `ready`, and the next window opens on the same closing edge.
- R9: `xtal_ok` = 1 after a crystal measurement whose result is within E ± floor(E/2000), where E = floor(REF_MHZ·10^6·N / 32768). It is 0 for other sources and is cleared at start.
- R10: After reset, `busy`, `ready`, `overflow` and `xtal_ok` are 0 and `result` is 0.
- R11: `busy` is 1 from the cycle after a start edge until a single-shot window completes, and is 0 when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, reference domain |
| slow_mux_clk | input | 1 | Slow-clock mux output (select 0/3) |
| rc_div_clk | input | 1 | RC oscillator divided by 256 (select 1) |
| xtal_clk | input | 1 | 32 kHz crystal (select 2) |
| cfg_sel | input | 2 | Source select |
| cfg_cycles | input | CYC_W | Slow periods to measure (N) |
| cfg_start | input | 1 | Start bit, acts on its rising edge |
| cfg_cont | input | 1 | Continuous mode |
| ready_clr | input | 1 | Clears ready |
| busy | output | 1 | Measurement in progress |
| ready | output | 1 | Result valid |
| result | output | CNT_W | Reference cycles counted |
| overflow | output | 1 | Counter saturated (sticky until start) |
| xtal_ok | output | 1 | Crystal within tolerance |

## Verification
A slow rising edge takes effect three reference edges after it occurs: two synchronizer stages, then the edge-detect stage that the state machine samples. That latency is identical for the opening and the closing edge, so the expected result is N times the slow period, with no ±1 slack. The bench generates each slow clock with half-periods that are whole multiples of the reference period, offset by 1 ns from the reference edges. This makes every count exact. `ready`, `result` and `xtal_ok` change on the same reference edge. The bench polls at falling edges and checks all three on the first falling edge where `ready` is high. Effects of a start (`ready` cleared, `busy` set) are checked on the falling edge right after the edge that samples the new start level.

// File: rtl/slow_cal_pkg.sv
package slow_cal_pkg;
  typedef enum logic [1:0] {
    SRC_MUX  = 2'd0,
    SRC_RC   = 2'd1,
    SRC_XTAL = 2'd2,
    SRC_ALT  = 2'd3
  } src_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } cal_state_e;

  localparam int NUM_SRC = 3;

  function automatic int unsigned src_index(input logic [1:0] sel);
    case (sel)
      SRC_RC:   return 1;
      SRC_XTAL: return 2;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/slow_cal_sync_edge.sv
module slow_cal_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], async_in};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/slow_cal_xtal_check.sv
module slow_cal_xtal_check #(
  parameter int CYC_W   = 15,
  parameter int CNT_W   = 25,
  parameter int REF_MHZ = 40
) (
  input  logic [CYC_W-1:0] cycles,
  input  logic [CNT_W-1:0] count,
  output logic             in_window
);
  localparam logic [63:0] REF_HZ = 64'(REF_MHZ) * 64'd1000000;

  logic [63:0] nominal, slack, meas;

  always_comb begin
    nominal   = (REF_HZ * 64'(cycles)) >> 15;
    slack     = nominal / 64'd2000;
    meas      = 64'(count);
    in_window = (meas >= nominal - slack) && (meas <= nominal + slack);
  end
endmodule

// File: rtl/slow_cal_counter.sv
module slow_cal_counter
  import slow_cal_pkg::*;
#(
  parameter int CYC_W       = 15,
  parameter int CNT_W       = 25,
  parameter int REF_MHZ     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_mux_clk,
  input  logic             rc_div_clk,
  input  logic             xtal_clk,
  input  logic [1:0]       cfg_sel,
  input  logic [CYC_W-1:0] cfg_cycles,
  input  logic             cfg_start,
  input  logic             cfg_cont,
  input  logic             ready_clr,
  output logic             busy,
  output logic             ready,
  output logic [CNT_W-1:0] result,
  output logic             overflow,
  output logic             xtal_ok
);
  logic [NUM_SRC-1:0] src_clk, src_rise;
  assign src_clk = {xtal_clk, rc_div_clk, slow_mux_clk};

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
      slow_cal_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_clk[i]),
        .rise     (src_rise[i])
      );
    end
  endgenerate

  cal_state_e       state;
  logic [1:0]       sel_q;
  logic [CYC_W-1:0] cyc_q, edges;
  logic             cont_q, start_q;
  logic [CNT_W-1:0] cnt;

  logic             start_rise, slow_rise, hit;
  logic [CNT_W-1:0] cnt_next;
  logic [CYC_W-1:0] edges_next;

  assign start_rise = cfg_start & ~start_q;
  assign slow_rise  = src_rise[src_index(sel_q)];
  assign cnt_next   = (&cnt) ? cnt : cnt + 1'b1;
  assign edges_next = edges + 1'b1;
  assign busy       = (state != ST_IDLE);

  slow_cal_xtal_check #(.CYC_W(CYC_W), .CNT_W(CNT_W), .REF_MHZ(REF_MHZ)) u_chk_win (
    .cycles    (cyc_q),
    .count     (cnt_next),
    .in_window (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel_q    <= '0;
      cyc_q    <= '0;
      cont_q   <= 1'b0;
      start_q  <= 1'b0;
      edges    <= '0;
      cnt      <= '0;
      ready    <= 1'b0;
      result   <= '0;
      overflow <= 1'b0;
      xtal_ok  <= 1'b0;
    end else begin
      start_q <= cfg_start;
      if (ready_clr) ready <= 1'b0;
      if (start_rise) begin
        state    <= ST_ARM;
        sel_q    <= cfg_sel;
        cyc_q    <= cfg_cycles;
        cont_q   <= cfg_cont;
        ready    <= 1'b0;
        overflow <= 1'b0;
        xtal_ok  <= 1'b0;
      end else begin
        case (state)
          ST_ARM: begin
            if (slow_rise) begin
              cnt   <= '0;
              edges <= '0;
              if (cyc_q == '0) begin
                result  <= '0;
                ready   <= 1'b1;
                xtal_ok <= 1'b0;
                state   <= cont_q ? ST_ARM : ST_IDLE;
              end else begin
                state <= ST_COUNT;
              end
            end
          end
          ST_COUNT: begin
            cnt <= cnt_next;
            if (&cnt) overflow <= 1'b1;
            if (slow_rise) begin
              edges <= edges_next;
              if (edges_next == cyc_q) begin
                result  <= cnt_next;
                ready   <= 1'b1;
                xtal_ok <= hit && (sel_q == SRC_XTAL);
                cnt     <= '0;
                edges   <= '0;
                if (!cont_q) state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/slow_cal_checker.sv
module slow_cal_checker #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_start,
  input logic             busy,
  input logic             ready,
  input logic [CNT_W-1:0] result,
  input logic             overflow
);
  logic start_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_seen <= 1'b0;
    else        start_seen <= cfg_start;
  end

  logic launch;
  assign launch = cfg_start & ~start_seen;

  // R5: a new result is only written together with ready
  assert_result_with_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ready);

  // R11: ready only rises at the end of an active measurement
  assert_ready_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(busy));

  // R7: a start edge clears ready and makes the block busy
  assert_start_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && !ready));

  // R6: overflow is sticky until a start edge
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !launch) |=> overflow);
endmodule

bind slow_cal_counter slow_cal_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_start (cfg_start),
  .busy      (busy),
  .ready     (ready),
  .result    (result),
  .overflow  (overflow)
);

// File: tb/sim_slow_cal_counter.sv
`timescale 1ns/1ps
module sim_slow_cal_counter;
  localparam int CYC_W = 15;
  localparam int CNT_W = 14;
  localparam int REF_MHZ = 250;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_mux_clk = 1'b0, rc_div_clk = 1'b0, xtal_clk = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [CYC_W-1:0] cfg_cycles = '0;
  logic cfg_start = 1'b0, cfg_cont = 1'b0, ready_clr = 1'b0;
  logic busy, ready, overflow, xtal_ok;
  logic [CNT_W-1:0] result;

  int checks = 0, failures = 0;
  int xtal_half = 3815;

  always #2 clk = ~clk;
  initial begin #1; forever #20 slow_mux_clk = ~slow_mux_clk; end
  initial begin #1; forever #32 rc_div_clk = ~rc_div_clk; end
  initial begin #1; forever #(xtal_half * 4) xtal_clk = ~xtal_clk; end

  slow_cal_counter #(.CYC_W(CYC_W), .CNT_W(CNT_W), .REF_MHZ(REF_MHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_mux_clk(slow_mux_clk), .rc_div_clk(rc_div_clk),
    .xtal_clk(xtal_clk), .cfg_sel(cfg_sel), .cfg_cycles(cfg_cycles), .cfg_start(cfg_start),
    .cfg_cont(cfg_cont), .ready_clr(ready_clr), .busy(busy), .ready(ready),
    .result(result), .overflow(overflow), .xtal_ok(xtal_ok));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input int sel, input int n, input logic cont);
    @(negedge clk);
    cfg_sel = 2'(sel); cfg_cycles = CYC_W'(n); cfg_cont = cont; cfg_start = 1'b0;
    @(negedge clk); cfg_start = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    while (!ready && t < 40000) begin @(negedge clk); t++; end
    if (!ready) begin
      checks++; failures++;
      $display("FAIL %s actual=timeout expected=ready", req);
    end
  endtask

  // sel, N, expected result, expected xtal_ok
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{0, 1, 10, 0},
    '{0, 5, 50, 0},
    '{1, 3, 48, 0},
    '{1, 1, 16, 0},
    '{0, 100, 1000, 0},
    '{3, 4, 40, 0},
    '{2, 1, 7630, 1},
    '{2, 2, 15260, 1}
  };

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 0);
    check("R10 ready", ready, 0);
    check("R10 result", result, 0);
    check("R10 overflow", overflow, 0);
    check("R10 xtal_ok", xtal_ok, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][0], VEC[i][1], 1'b0);
      check("R7 start clears ready", ready, 0);
      check("R11 busy after start", busy, 1);
      wait_ready("R3");
      check("R3/R1 result", result, VEC[i][2]);
      check("R9 xtal_ok", xtal_ok, VEC[i][3]);
      check("R6 no overflow", overflow, 0);
      @(negedge clk);
      check("R11 idle after single shot", busy, 0);
    end

    // R2 level-held start does not retrigger; R5 clear
    repeat (60) @(negedge clk);
    check("R2 no retrigger busy", busy, 0);
    check("R2 ready held", ready, 1);
    ready_clr = 1'b1; @(negedge clk); ready_clr = 1'b0;
    check("R5 ready_clr", ready, 0);
    repeat (30) @(negedge clk);
    check("R2 still idle", busy, 0);

    // R9 crystal out of tolerance
    xtal_half = 3790;
    launch(2, 1, 1'b0);
    wait_ready("R9");
    check("R9 bad xtal result", result, 7580);
    check("R9 bad xtal flag", xtal_ok, 0);
    xtal_half = 3815;

    // R6 saturation
    launch(2, 3, 1'b0);
    wait_ready("R6");
    check("R6 saturated result", result, 16383);
    check("R6 overflow set", overflow, 1);
    launch(0, 1, 1'b0);
    check("R6 overflow cleared by start", overflow, 0);
    wait_ready("R6");
    check("R6 fresh result", result, 10);

    // R4 zero cycles
    launch(1, 0, 1'b0);
    wait_ready("R4");
    check("R4 zero result", result, 0);
    @(negedge clk);
    check("R4 idle", busy, 0);

    // R7 restart mid-measurement
    launch(0, 5, 1'b0);
    wait_ready("R7");
    launch(0, 100, 1'b0);
    repeat (200) @(negedge clk);
    cfg_start = 1'b0; @(negedge clk); cfg_start = 1'b1; @(negedge clk);
    check("R7 restart ready", ready, 0);
    check("R7 restart busy", busy, 1);
    wait_ready("R7");
    check("R7 restart result", result, 1000);

    // R8 continuous mode
    launch(0, 2, 1'b1);
    wait_ready("R8");
    check("R8 first window", result, 20);
    ready_clr = 1'b1; @(negedge clk); ready_clr = 1'b0;
    check("R8 cleared", ready, 0);
    wait_ready("R8");
    check("R8 second window", result, 20);
    check("R8 still busy", busy, 1);
    launch(0, 1, 1'b0);
    wait_ready("R8");
    @(negedge clk);
    check("R8 back to single shot", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule